// File: doc/BRIEF.md
# DRAM strobe cycle classifier

This block watches the control strobes of an asynchronous page-mode DRAM, sampled by a fast system clock, and names each bus operation as it finishes. It is meant as the front end of a behavioural memory model or a bus monitor: the classification comes only from the order in which row strobe, column strobe and write enable change, never from analog timing. A column access whose row strobe fell with the column strobe high is a data access; a row strobe that falls while the column strobe is already low is a refresh of some kind.

Besides the operation code, the block keeps the latched parallel test state, entered by a refresh with write enable low and left by the next ordinary refresh. While that state is set, the read data it presents per data line is a pass/fail flag comparing the two internal cells behind that line, so the lowest column bit no longer chooses between them. It also flags a write-enable transition that fits neither write style, and offers a drive-enable for the data lines of a read.

Top module: `dram_cyc_classifier`

## Requirements
- R1: The first column access of a row-strobe-low period is reported with code 1 (read: WE high at column fall and staying high), 2 (early write: WE low when the column strobe falls) or 3 (read-modify-write: WE high at column fall, then falling while the column strobe stays low); the report is made when the column strobe rises, or when the row strobe rises while the column strobe is still low.
- R2: Every further column access in the same row-strobe-low period is reported with code 0, and each column-strobe fall in an access period latches the address onto col_addr.
- R3: A row-strobe-low period with the column strobe high at its start and no column-strobe fall inside it is reported, when the row strobe rises, with code 4.
- R4: A row-strobe fall with the column strobe already low, WE high and no preceding held access is reported, when the row strobe rises, with code 5.
- R5: The same sequence with WE low is reported with code 7 and sets test_mode.
- R6: test_mode stays set across data accesses and is cleared by a period reported with code 4, 5 or 6.
- R7: When an access period ends with the row strobe rising while the column strobe stays low, and the row strobe then falls again with the column strobe still low, that second period is reported with code 6.
- R8: rd_data bit i equals cell_bits[i] when latched column bit 0 is 0 and cell_bits[DQ_W+i] when it is 1; while test_mode is set, bit i is 1 when those two cells are equal and 0 otherwise, whatever column bit 0 is.
- R9: proto_err pulses for one clock when WE rises while the column strobe is low inside an access period.
- R10: cyc_vld is a one-clock pulse, raised in the clock after the sample that completes the operation, exactly once per reported operation.
- R11: dq_oe is high while a read or read-modify-write column access is active and OE is low, and low during an early write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | COL_W | Multiplexed address lines |
| cell_bits | input | 2*DQ_W | Two internal cells per data line, low half selected by column bit 0 = 0 |
| cyc_vld | output | 1 | One-clock pulse with each reported operation |
| cyc_code | output | 3 | Operation code, valid with cyc_vld |
| proto_err | output | 1 | One-clock pulse on an illegal WE rise |
| test_mode | output | 1 | Latched parallel test state |
| col_addr | output | COL_W | Last latched column address |
| rd_data | output | DQ_W | Read data or per-line compare result |
| dq_oe | output | 1 | Data-line drive enable for reads |

## Verification
The properties assume that the strobes are synchronous to the sampling clock and that the row and column strobes never change in the same sample, since the order of two edges caught in one sample cannot be recovered. They also take for granted that the column strobe stays low for the whole of a hidden refresh. The stimulus moves each strobe on its own falling clock edge, keeps at least one sample between row and column transitions, and holds the column strobe low until after the hidden period has ended.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   typedef enum logic [2:0] {
      CYC_PAGE = 3'd0,
      CYC_READ = 3'd1,
      CYC_EWR  = 3'd2,
      CYC_RMW  = 3'd3,
      CYC_ROR  = 3'd4,
      CYC_CBR  = 3'd5,
      CYC_HID  = 3'd6,
      CYC_TST  = 3'd7
   } cyc_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACC  = 2'd1,
      PH_REF  = 2'd2
   } ph_e;
endpackage

// File: rtl/dcc_edges.sv
module dcc_edges #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] prev,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      assign fall[i] = prev[i] & ~lvl[i];
      assign rise[i] = ~prev[i] & lvl[i];
   end
endmodule

// File: rtl/dcc_seq.sv
module dcc_seq
   import dcc_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_f,
   input  logic             ras_r,
   input  logic             cas_f,
   input  logic             cas_r,
   input  logic             we_f,
   input  logic             we_r,
   input  logic             cas_prev,
   input  logic             we_n,
   input  logic [COL_W-1:0] addr,
   output logic             vld,
   output cyc_e             code,
   output logic             err,
   output logic             tmode,
   output logic [COL_W-1:0] col,
   output logic             in_col,
   output logic             rd_kind
);
   ph_e  ph_q;
   cyc_e ref_q, kind_q;
   logic seen_q, hid_q;

   assign rd_kind = (kind_q != CYC_EWR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         ref_q  <= CYC_CBR;
         kind_q <= CYC_READ;
         in_col <= 1'b0;
         seen_q <= 1'b0;
         hid_q  <= 1'b0;
         tmode  <= 1'b0;
         col    <= '0;
         vld    <= 1'b0;
         code   <= CYC_PAGE;
         err    <= 1'b0;
      end else begin
         vld <= 1'b0;
         err <= 1'b0;
         if (cas_r) hid_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (ras_f) begin
                  if (!cas_prev) begin
                     ph_q  <= PH_REF;
                     ref_q <= hid_q ? CYC_HID : (we_n ? CYC_CBR : CYC_TST);
                  end else begin
                     ph_q   <= PH_ACC;
                     seen_q <= 1'b0;
                     in_col <= 1'b0;
                  end
               end
            end
            PH_ACC: begin
               if (cas_f && !ras_r) begin
                  in_col <= 1'b1;
                  kind_q <= we_n ? CYC_READ : CYC_EWR;
                  col    <= addr;
               end
               if (in_col && we_f && kind_q == CYC_READ && !cas_r && !ras_r)
                  kind_q <= CYC_RMW;
               if (in_col && we_r && !cas_r && !ras_r)
                  err <= 1'b1;
               if (in_col && (cas_r || ras_r)) begin
                  vld    <= 1'b1;
                  code   <= seen_q ? CYC_PAGE : kind_q;
                  seen_q <= 1'b1;
                  in_col <= 1'b0;
               end
               if (ras_r) begin
                  ph_q  <= PH_IDLE;
                  hid_q <= in_col && !cas_r;
                  if (!in_col && !seen_q) begin
                     vld   <= 1'b1;
                     code  <= CYC_ROR;
                     tmode <= 1'b0;
                  end
               end
            end
            PH_REF: begin
               if (ras_r) begin
                  ph_q  <= PH_IDLE;
                  vld   <= 1'b1;
                  code  <= ref_q;
                  tmode <= (ref_q == CYC_TST);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dcc_tcmp.sv
module dcc_tcmp #(
   parameter int DQ_W = 4
) (
   input  logic [2*DQ_W-1:0] cell_bits,
   input  logic              col0,
   input  logic              tmode,
   output logic [DQ_W-1:0]   rd_data
);
   for (genvar i = 0; i < DQ_W; i++) begin : g_dq
      logic lo, hi;
      assign lo = cell_bits[i];
      assign hi = cell_bits[DQ_W+i];
      assign rd_data[i] = tmode ? ~(lo ^ hi) : (col0 ? hi : lo);
   end
endmodule

// File: rtl/dram_cyc_classifier.sv
module dram_cyc_classifier
   import dcc_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int DQ_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [COL_W-1:0]  addr,
   input  logic [2*DQ_W-1:0] cell_bits,
   output logic              cyc_vld,
   output logic [2:0]        cyc_code,
   output logic              proto_err,
   output logic              test_mode,
   output logic [COL_W-1:0]  col_addr,
   output logic [DQ_W-1:0]   rd_data,
   output logic              dq_oe
);
   localparam int NLINE = 3;

   if (COL_W < 1) begin : g_bad_col
      $error("COL_W must be at least 1");
   end
   if (DQ_W < 1) begin : g_bad_dq
      $error("DQ_W must be at least 1");
   end

   logic [NLINE-1:0] prev, fall, rise;
   cyc_e code;
   logic in_col, rd_kind;

   dcc_edges #(.N(NLINE)) i_edges (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  ({we_n, cas_n, ras_n}),
      .prev (prev),
      .fall (fall),
      .rise (rise)
   );

   dcc_seq #(.COL_W(COL_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_f   (fall[0]),
      .ras_r   (rise[0]),
      .cas_f   (fall[1]),
      .cas_r   (rise[1]),
      .we_f    (fall[2]),
      .we_r    (rise[2]),
      .cas_prev(prev[1]),
      .we_n    (we_n),
      .addr    (addr),
      .vld     (cyc_vld),
      .code    (code),
      .err     (proto_err),
      .tmode   (test_mode),
      .col     (col_addr),
      .in_col  (in_col),
      .rd_kind (rd_kind)
   );

   dcc_tcmp #(.DQ_W(DQ_W)) i_tcmp (
      .cell_bits(cell_bits),
      .col0     (col_addr[0]),
      .tmode    (test_mode),
      .rd_data  (rd_data)
   );

   assign cyc_code = code;
   assign dq_oe    = in_col && rd_kind && !oe_n;
endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
   parameter int DQ_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              cyc_vld,
   input logic [2:0]        cyc_code,
   input logic              proto_err,
   input logic              test_mode,
   input logic [2*DQ_W-1:0] cell_bits,
   input logic [DQ_W-1:0]   rd_data
);
   // R5: test state only appears together with a test-entry report
   p_tm_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_mode) |-> (cyc_vld && cyc_code == 3'd7));

   // R6: test state only drops with a refresh report
   p_tm_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_mode) |-> (cyc_vld && (cyc_code == 3'd4 || cyc_code == 3'd5 || cyc_code == 3'd6)));

   // R3: a row-only refresh is reported after the row strobe rose with the column strobe high
   p_ror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_vld && cyc_code == 3'd4) |-> ($past(ras_n) && $past(cas_n)));

   // R4: refresh-type reports follow a row strobe rise
   p_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_vld && cyc_code >= 3'd5) |-> $past(ras_n));

   // R9: the error comes from WE high while the column strobe was low
   p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($past(we_n) && !$past(cas_n)));

   // R10: a report lasts a single clock
   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_vld |=> !cyc_vld);

   // R8: in test mode the column address has no influence on read data
   p_tm_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && $stable(test_mode) && $stable(cell_bits)) |-> $stable(rd_data));
endmodule

bind dram_cyc_classifier dcc_chk #(.DQ_W(DQ_W)) i_chk (.*);

// File: tb/test_dram_cyc_classifier.sv
module test_dram_cyc_classifier;
   localparam int COL_W = 10;
   localparam int DQ_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [COL_W-1:0]  addr = '0;
   logic [2*DQ_W-1:0] cell_bits = '0;
   logic              cyc_vld, proto_err, test_mode, dq_oe;
   logic [2:0]        cyc_code;
   logic [COL_W-1:0]  col_addr;
   logic [DQ_W-1:0]   rd_data;

   int n_chk = 0, n_bad = 0;
   bit tm_exp = 0;
   bit done = 0;
   logic [2:0] expq[$];

   always #2 clk = ~clk;

   dram_cyc_classifier #(.COL_W(COL_W), .DQ_W(DQ_W)) i_dram_cyc_classifier (.*);

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor side of the scoreboard (R10: one pulse per queued item)
   always @(negedge clk) begin
      if (rst_n && !done && cyc_vld) begin
         if (expq.size() == 0) chk(0, "R10 unexpected report", cyc_code, -1);
         else begin
            logic [2:0] e;
            e = expq.pop_front();
            chk(cyc_code == e, "R1-code scoreboard", cyc_code, e);
         end
      end
   end

   function automatic logic [DQ_W-1:0] exp_rd(input logic c0, input bit tm);
      logic [DQ_W-1:0] r;
      for (int i = 0; i < DQ_W; i++)
         r[i] = tm ? (cell_bits[i] == cell_bits[DQ_W+i]) : (c0 ? cell_bits[DQ_W+i] : cell_bits[i]);
      return r;
   endfunction

   // kind: 1 read, 2 early write, 3 read-modify-write
   task automatic acc(input logic [COL_W-1:0] c, input int kind, input bit page);
      addr  = c;
      we_n  = (kind == 2) ? 1'b0 : 1'b1;
      cas_n = 1'b0;
      step(1);
      chk(col_addr == c, "R2 column latch", col_addr, c);
      chk(dq_oe == (kind != 2), "R11 drive enable", dq_oe, kind != 2);
      if (kind != 2) chk(rd_data == exp_rd(c[0], tm_exp), "R8 read data", rd_data, exp_rd(c[0], tm_exp));
      if (kind == 3) begin
         we_n = 1'b0;
         step(1);
      end
      step(1);
      cas_n = 1'b1;
      expq.push_back(page ? 3'd0 : 3'(kind));
      step(1);
      we_n = 1'b1;
      step(1);
   endtask

   task automatic ras_only();
      ras_n = 1'b0;
      step(2);
      ras_n = 1'b1;
      expq.push_back(3'd4);
      tm_exp = 0;
      step(2);
      chk(test_mode == tm_exp, "R3 R6 test flag after row-only", test_mode, tm_exp);
   endtask

   task automatic cbr(input logic w);
      cas_n = 1'b0;
      we_n  = w;
      step(1);
      ras_n = 1'b0;
      step(2);
      ras_n = 1'b1;
      expq.push_back(w ? 3'd5 : 3'd7);
      tm_exp = !w;
      step(1);
      cas_n = 1'b1;
      we_n  = 1'b1;
      step(2);
      chk(test_mode == tm_exp, w ? "R4 R6 test flag after refresh" : "R5 test flag set", test_mode, tm_exp);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(cyc_vld == 0, "R10 reset vld", cyc_vld, 0);
      chk(test_mode == 0, "R5 reset test flag", test_mode, 0);
      chk(proto_err == 0, "R9 reset error", proto_err, 0);

      // R1: single accesses of each kind
      cell_bits = 8'hA5;
      ras_n = 1'b0; step(1); acc(10'h012, 1, 0); ras_n = 1'b1; step(2);
      ras_n = 1'b0; step(1); acc(10'h0F1, 2, 0); ras_n = 1'b1; step(2);
      ras_n = 1'b0; step(1); acc(10'h201, 3, 0); ras_n = 1'b1; step(2);

      // R2: page accesses
      cell_bits = 8'h3C;
      ras_n = 1'b0; step(1);
      acc(10'h100, 1, 0); acc(10'h101, 2, 1); acc(10'h102, 3, 1); acc(10'h103, 1, 1);
      ras_n = 1'b1; step(2);

      // R3, R4
      ras_only();
      cbr(1'b1);

      // R5, R8: test mode reads ignore column bit 0
      cbr(1'b0);
      cell_bits = 8'h96;
      ras_n = 1'b0; step(1); acc(10'h040, 1, 0); acc(10'h041, 1, 1); ras_n = 1'b1; step(2);
      cell_bits = 8'h33;
      ras_n = 1'b0; step(1); acc(10'h005, 1, 0); ras_n = 1'b1; step(2);
      chk(test_mode == 1, "R6 test flag kept over accesses", test_mode, 1);
      cbr(1'b1);
      cbr(1'b0);
      ras_only();

      // R7: hidden refresh after a held read
      cbr(1'b0);
      ras_n = 1'b0; step(1);
      addr = 10'h077; cas_n = 1'b0; step(2);
      ras_n = 1'b1; expq.push_back(3'd1); step(1);
      ras_n = 1'b0; step(2);
      ras_n = 1'b1; expq.push_back(3'd6); tm_exp = 0; step(1);
      cas_n = 1'b1; step(2);
      chk(test_mode == 0, "R7 R6 hidden refresh clears test flag", test_mode, 0);

      // R9: WE rising inside an early write
      ras_n = 1'b0; step(1);
      we_n = 1'b0; cas_n = 1'b0; step(1);
      chk(proto_err == 0, "R9 no error at column fall", proto_err, 0);
      we_n = 1'b1; step(1);
      chk(proto_err == 1, "R9 error pulse", proto_err, 1);
      step(1);
      chk(proto_err == 0, "R9 error single clock", proto_err, 0);
      cas_n = 1'b1; expq.push_back(3'd2); step(1);
      ras_n = 1'b1; step(3);

      chk(expq.size() == 0, "R10 all reports seen", expq.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      step(200000);
      if (!done) begin
         chk(0, "watchdog", 0, 1);
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule